// File: doc/BRIEF.md
# Configuration-Space Base Address Decoder

This block holds the configuration registers of a small type-0 endpoint and turns incoming addresses into a window index and an offset. System software reads the identity, class and header-type words, writes the 16-bit command register, and programs two base address registers. Slot 0 is a one-byte I/O window. Slot 1 is a 256-byte 32-bit memory window. Slots 2 to 5 are not implemented.

The configuration port is a plain register port. It takes a dword index, a write strobe and write data, and it returns combinational read data for the index that is presented. The decode port is also combinational. It compares a 32-bit address with the bases that are stored at that moment and reports a hit, the number of the matching slot, and the byte offset inside that slot.

Top module: `cfgbar_decoder`

## Requirements
- R1: After reset, the command register reads 0, slot 0 reads 0x00000001 and slot 1 reads 0x00000000.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor identifier in bits 15:0. Dword 2 reads {CLASS_CODE, 8'h00}. Dword 3 reads 0, so the header type in bits 23:16 is 0. Every dword index from 10 to 63 reads 0.
- R3: A write to dword 1 stores wdata[15:0] as the command value. Dword 1 then reads {16'h0000, command}.
- R4: Slot 0 is dword 4. A write stores wdata with bit 0 forced to 1, and the slot reads back the stored word unchanged. Bit 0 (I/O space) therefore always reads 1.
- R5: Slot 1 is dword 5. A write stores wdata with bit 0 forced to 0. The slot reads back the stored word with bits 7:0 cleared, so a write of all ones reads back 0xFFFFFF00.
- R6: Writes to dwords 0, 2, 3, 6 to 9 and 10 to 63 change nothing that can be read. Dwords 6 to 9 (slots 2 to 5) always read 0.
- R7: The base of a slot is its stored word with bit 0 cleared. An address hits a slot when base <= addr < base + size, where the size is 1 for slot 0 and 256 for slot 1. The sum is formed without wrapping at 2^32. On a hit, dec_off = addr - base.
- R8: When both windows contain the address, slot 0 is reported. dec_bar gives the slot number.
- R9: When no window contains the address, dec_hit is 0, dec_bar is 0 and dec_off is 0.
- R10: Read data and decode results come from the register values held before a clock edge. A write becomes visible to reads and to decode only after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| dec_addr | input | 32 | Address to decode |
| dec_hit | output | 1 | Address falls in an implemented window |
| dec_bar | output | 3 | Index of the matching slot |
| dec_off | output | 32 | Byte offset inside the matching window |

## Verification
A base write and a decode of an address near that base can occur in the same cycle. The same holds for a command or base write and a read of the same dword. The bench raises the strobe with both ports loaded and samples before the edge. At that point the old base and old read value must still show. After the edge it checks the new ones. The random mix keeps decode addresses close to the live bases, so this overlap happens often, and directed cases add overlapping windows and windows at the very top of the address space.

// File: rtl/cfgbar_pkg.sv
// Shared constants and helpers for the configuration-space base decoder.
// Assumes a 32-bit dword register port and six base-address slots.
package cfgbar_pkg;
    localparam int NUM_SLOTS  = 6;
    localparam int SLOT_W     = 3;
    localparam int DATA_W     = 32;
    localparam int CFG_AW     = 6;

    // Dword indices whose positions software depends on.
    localparam logic [CFG_AW-1:0] IDX_IDENT  = 6'd0;
    localparam logic [CFG_AW-1:0] IDX_CMD    = 6'd1;
    localparam logic [CFG_AW-1:0] IDX_CLASS  = 6'd2;
    localparam logic [CFG_AW-1:0] IDX_HDR    = 6'd3;
    localparam logic [CFG_AW-1:0] IDX_SLOT0  = 6'd4;

    // Size in bytes of slot i; zero marks an unimplemented slot.
    function automatic int unsigned slot_bytes(int i, int unsigned b0, int unsigned b1);
        return (i == 0) ? b0 : (i == 1) ? b1 : 0;
    endfunction

    // Mask that keeps the base bits above the window size.
    function automatic logic [DATA_W-1:0] size_mask(int unsigned bytes);
        return ~(DATA_W'(bytes) - DATA_W'(1));
    endfunction
endpackage

// File: rtl/cfgbar_slot.sv
// One implemented base-address slot: storage, readback and address window.
// Assumes BYTES is a nonzero power of two; IS_IO selects the fixed space bit.
module cfgbar_slot
    import cfgbar_pkg::*;
#(
    parameter int unsigned BYTES = 256,
    parameter bit          IS_IO = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] rd_val,
    output logic              hit,
    output logic [DATA_W-1:0] off
);
    localparam logic [DATA_W-1:0] TYPE_BITS = IS_IO ? DATA_W'(1) : '0;
    localparam logic [DATA_W-1:0] KEEP_MASK = size_mask(BYTES);

    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] base;
    logic [DATA_W:0]   limit;

    // Capture written base with the space bit re-imposed.
    always_ff @(posedge clk) begin
        if (!rst_n)      stored <= TYPE_BITS;
        else if (wr_en)  stored <= wdata | TYPE_BITS;
    end

    // Readback hides the bits below the window size.
    always_comb rd_val = (stored & KEEP_MASK) | TYPE_BITS;

    // Window compare done in one extra bit so the top never wraps.
    always_comb begin
        base  = stored & ~DATA_W'(1);
        limit = {1'b0, base} + (DATA_W+1)'(BYTES);
        hit   = ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} < limit);
        off   = hit ? (addr - base) : '0;
    end
endmodule

// File: rtl/cfgbar_first_hit.sv
// Picks the lowest-numbered window that matched and forwards its offset.
// Assumes per-slot offsets are already zero when a slot did not match.
module cfgbar_first_hit
    import cfgbar_pkg::*;
(
    input  logic [NUM_SLOTS-1:0]             hits,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] offs,
    output logic                             any,
    output logic [SLOT_W-1:0]                idx,
    output logic [DATA_W-1:0]                off
);
    // Scan downward so the lowest matching slot is assigned last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        off = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = SLOT_W'(i);
                off = offs[i];
            end
        end
    end
endmodule

// File: rtl/cfgbar_rdmux.sv
// Selects configuration read data for a dword index.
// Assumes slot values are pre-formatted; unlisted indices read zero.
module cfgbar_rdmux
    import cfgbar_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID  = 16'h5A5A,
    parameter logic [23:0] CLASS_CODE = 24'hFF0000
) (
    input  logic [CFG_AW-1:0]                addr,
    input  logic [15:0]                      cmd,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_rd,
    output logic [DATA_W-1:0]                rdata
);
    // Fixed words, command and slot readback multiplexed by index.
    always_comb begin
        rdata = '0;
        if (addr == IDX_IDENT)      rdata = {DEVICE_ID, VENDOR_ID};
        else if (addr == IDX_CMD)   rdata = {16'h0000, cmd};
        else if (addr == IDX_CLASS) rdata = {CLASS_CODE, 8'h00};
        else if (addr == IDX_HDR)   rdata = '0;
        else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (addr == IDX_SLOT0 + CFG_AW'(i)) rdata = slot_rd[i];
            end
        end
    end
endmodule

// File: rtl/cfgbar_decoder.sv
// Configuration registers and base-address decode for a type-0 endpoint.
// Assumes window sizes are powers of two; slot 0 is I/O, slot 1 is memory.
module cfgbar_decoder
    import cfgbar_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID  = 16'h5A5A,
    parameter logic [23:0] CLASS_CODE = 24'hFF0000,
    parameter int unsigned BAR0_BYTES = 1,
    parameter int unsigned BAR1_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       dec_addr,
    output logic              dec_hit,
    output logic [2:0]        dec_bar,
    output logic [31:0]       dec_off
);
    logic [15:0]                      cmd_q;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_rd;
    logic [NUM_SLOTS-1:0]             slot_hit;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_off;

    // Command register holds the low half of the last write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cmd_q <= '0;
        else if (cfg_wr && cfg_addr == IDX_CMD) cmd_q <= cfg_wdata[15:0];
    end

    // One slot per implemented window; empty slots read zero, never hit.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam int unsigned SZ = slot_bytes(g, BAR0_BYTES, BAR1_BYTES);
        if (SZ != 0) begin : g_live
            cfgbar_slot #(.BYTES(SZ), .IS_IO(g == 0)) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (cfg_wr && cfg_addr == IDX_SLOT0 + CFG_AW'(g)),
                .wdata  (cfg_wdata),
                .addr   (dec_addr),
                .rd_val (slot_rd[g]),
                .hit    (slot_hit[g]),
                .off    (slot_off[g])
            );
        end else begin : g_empty
            assign slot_rd[g]  = '0;
            assign slot_hit[g] = 1'b0;
            assign slot_off[g] = '0;
        end
    end

    cfgbar_first_hit u_pick (
        .hits (slot_hit),
        .offs (slot_off),
        .any  (dec_hit),
        .idx  (dec_bar),
        .off  (dec_off)
    );

    cfgbar_rdmux #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .CLASS_CODE (CLASS_CODE)
    ) u_rd (
        .addr    (cfg_addr),
        .cmd     (cmd_q),
        .slot_rd (slot_rd),
        .rdata   (cfg_rdata)
    );
endmodule

// File: rtl/cfgbar_decoder_chk.sv
// Port-level properties of the decoder, bound onto every instance.
module cfgbar_decoder_chk #(
    parameter int unsigned BAR0_BYTES = 1,
    parameter int unsigned BAR1_BYTES = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [5:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        dec_hit,
    input logic [2:0]  dec_bar,
    input logic [31:0] dec_off
);
    assert_cmd_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == 6'd1) |=> (cfg_addr != 6'd1 || cfg_rdata[15:0] == $past(cfg_wdata[15:0])));

    assert_io_space_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'd4) |-> cfg_rdata[0]);

    assert_mem_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'd5) |-> (cfg_rdata & (BAR1_BYTES - 1)) == 0);

    assert_empty_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr >= 6'd6 && cfg_addr <= 6'd9) |-> cfg_rdata == 32'd0);

    assert_offset_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> ((dec_bar == 3'd0 && dec_off < BAR0_BYTES) || (dec_bar == 3'd1 && dec_off < BAR1_BYTES)));

    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_bar == 3'd0 && dec_off == 32'd0));
endmodule

bind cfgbar_decoder cfgbar_decoder_chk #(
    .BAR0_BYTES (BAR0_BYTES),
    .BAR1_BYTES (BAR1_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .dec_hit   (dec_hit),
    .dec_bar   (dec_bar),
    .dec_off   (dec_off)
);

// File: tb/cfgbar_decoder_bench.sv
`timescale 1ns/1ps
module cfgbar_decoder_bench;
    localparam logic [15:0] VEN = 16'hC0DE;
    localparam logic [15:0] DEV = 16'h5A5A;
    localparam logic [23:0] CLS = 24'hFF0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] dec_addr = '0;
    logic        dec_hit;
    logic [2:0]  dec_bar;
    logic [31:0] dec_off;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state kept by the bench.
    logic [15:0] m_cmd;
    logic [31:0] m_s0, m_s1;

    always #10 clk = ~clk;

    cfgbar_decoder #(.VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_CODE(CLS),
                     .BAR0_BYTES(1), .BAR1_BYTES(256)) u_cfgbar_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_addr(dec_addr),
        .dec_hit(dec_hit), .dec_bar(dec_bar), .dec_off(dec_off));

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        case (a)
            6'd0: return {DEV, VEN};
            6'd1: return {16'h0, m_cmd};
            6'd2: return {CLS, 8'h00};
            6'd4: return m_s0;
            6'd5: return m_s1 & 32'hFFFF_FF00;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [35:0] exp_dec(logic [31:0] a);
        logic [32:0] b0, b1;
        b0 = {1'b0, m_s0 & ~32'd1};
        b1 = {1'b0, m_s1 & ~32'd1};
        if ({1'b0, a} >= b0 && {1'b0, a} < b0 + 33'd1)   return {1'b1, 3'd0, a - b0[31:0]};
        if ({1'b0, a} >= b1 && {1'b0, a} < b1 + 33'd256) return {1'b1, 3'd1, a - b1[31:0]};
        return 36'd0;
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: load both ports, check pre-edge values, clock, update model.
    task automatic step(bit wr, logic [5:0] a, logic [31:0] wd, logic [31:0] da, string tag);
        @(negedge clk);
        cfg_wr = wr; cfg_addr = a; cfg_wdata = wd; dec_addr = da;
        #1;
        check({tag, " rd"}, {4'h0, cfg_rdata}, {4'h0, exp_rd(a)});
        check({tag, " dec"}, {dec_hit, dec_bar, dec_off}, exp_dec(da));
        @(posedge clk);
        if (wr) begin
            if (a == 6'd1) m_cmd = wd[15:0];
            if (a == 6'd4) m_s0 = wd | 32'd1;
            if (a == 6'd5) m_s1 = wd & ~32'd1;
        end
        #1 cfg_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_cmd = 16'h0; m_s0 = 32'h1; m_s1 = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        step(0, 6'd1, 0, 32'h100, "R1 cmd");
        step(0, 6'd4, 0, 32'h0, "R1 slot0");
        step(0, 6'd5, 0, 32'h1, "R1 slot1");
        // R2 fixed words and unlisted indices
        step(0, 6'd0, 0, 32'h0, "R2 ident");
        step(0, 6'd2, 0, 32'h0, "R2 class");
        step(0, 6'd3, 0, 32'h0, "R2 header");
        step(0, 6'd40, 0, 32'h0, "R2 unlisted");
        // R3 command; R10 same-cycle write then readback
        step(1, 6'd1, 32'hABCD_1234, 32'h0, "R10 cmd pre");
        step(0, 6'd1, 0, 32'h0, "R3 cmd");
        // R5 size probe
        step(1, 6'd5, 32'hFFFF_FFFF, 32'h0, "R5 probe wr");
        step(0, 6'd5, 0, 32'hFFFF_FFFF, "R5 probe rd / R7 top");
        step(0, 6'd5, 0, 32'h0000_0000, "R7 no wrap");
        // R4 space bit
        step(1, 6'd4, 32'h0000_1000, 32'h1000, "R4 wr / R10 old base");
        step(0, 6'd4, 0, 32'h1000, "R4 rd");
        // R8 overlapping windows
        step(1, 6'd5, 32'h0000_1000, 32'h1000, "R8 setup");
        step(0, 6'd5, 0, 32'h1000, "R8 overlap");
        step(0, 6'd5, 0, 32'h1001, "R7 offset");
        step(0, 6'd5, 0, 32'h10FF, "R7 last byte");
        step(0, 6'd5, 0, 32'h1100, "R9 past end");
        // R6 ignored writes
        step(1, 6'd0, 32'hFFFF_FFFF, 0, "R6 wr ident");
        step(1, 6'd7, 32'hFFFF_FFFF, 0, "R6 wr slot3");
        step(1, 6'd20, 32'hFFFF_FFFF, 0, "R6 wr high");
        step(0, 6'd0, 0, 0, "R6 ident");
        step(0, 6'd7, 0, 0, "R6 slot3");
        step(0, 6'd20, 0, 0, "R6 high");
        // Random mix near live bases
        for (int i = 0; i < 3000; i++) begin
            logic [5:0]  a;
            logic [31:0] wd, da;
            bit wr;
            a  = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 10);
            wr = ($urandom % 3 == 0);
            wd = ($urandom % 2) ? $urandom : ($urandom & 32'h0000_3FFF);
            case ($urandom % 3)
                0: da = (m_s0 & ~32'd1) + 32'($urandom % 4) - 32'd1;
                1: da = (m_s1 & ~32'd1) + 32'($urandom % 300) - 32'd20;
                default: da = $urandom;
            endcase
            step(wr, a, wd, da, "R7 R8 R10 random");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule